// File: doc/BRIEF.md
# Bootloader Entry Sequence Generator

This block takes over the reset and test/clock control lines of an attached target device. It toggles them through a fixed pattern that leaves the target running its serial bootloader. A single-cycle start request launches the pattern. A strap input picks one of two patterns: one for targets whose debug port has its own dedicated pins, and one for targets that share those pins with general I/O. Consecutive pin edges are spaced by a parameterised number of clock cycles. The default of 1259 cycles gives about 1.2 ms at a 1,048,576 Hz clock.

Each step changes exactly one line. After the last step the lines keep their levels, so the target stays in its bootloader while a separate serial engine talks to it. A busy flag covers the whole pattern. A one-cycle done pulse marks its end.

Top module: `boot_entry_seq`

## Requirements
- R1: After reset, the target reset line, TEST line and TCK line are all driven low, and busy and done are both low.
- R2: A start request seen at a clock edge while idle is accepted. Busy is high after that edge, and the first step is applied at that same edge.
- R3: With the strap high (dedicated pins), the seven steps are applied in this order: TCK to 1, reset to 0, TCK to 0, TCK to 1, TCK to 0, reset to 1, TCK to 1.
- R4: With the strap low (shared pins), the seven steps are applied in this order: reset to 0, TEST to 0, TEST to 1, TEST to 0, TEST to 1, reset to 1, TEST to 0.
- R5: Step k is applied exactly k×STEP_CYCLES clock edges after the accepting edge. No line changes between steps, and no edge changes more than one line.
- R6: The edge that applies the seventh step also drops busy and raises done. Done stays high for exactly one cycle.
- R7: A start request seen while busy has no effect. The pattern, its timing and its end are unchanged.
- R8: The strap is sampled only at the accepting edge. A change of the strap during the pattern does not change the remaining steps.
- R9: While idle with no start request, all three lines keep the levels left by the last step applied (or the reset levels).
- R10: A start request seen during the done cycle is accepted. A new pattern begins from the lines' current levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled at each rising edge |
| dedicated_i | input | 1 | Pattern strap: 1 = dedicated debug pins, 0 = shared pins |
| tgt_rst_n_o | output | 1 | Target reset line level (0 holds the target in reset) |
| tgt_test_o | output | 1 | Target TEST line level |
| tgt_tck_o | output | 1 | Target TCK line level |
| busy_o | output | 1 | High while a pattern is in progress |
| done_o | output | 1 | One-cycle pulse on the cycle after the final step |

## Verification
The end of one pattern and the acceptance of the next can fall at the same boundary. Done is high in the first idle cycle, and a start request sampled at the following edge must be accepted.

The bench raises start during the done cycle with the opposite strap value. It then expects busy high after the next edge, and the first step of the new pattern applied on top of the lines left by the old one.

A second overlap is also provoked: a start request and a strap flip are placed on the very edges that apply steps, including the final one. The bench expects the original pattern to continue, and done to appear once with no restart.

// File: rtl/bes_pkg.sv
package bes_pkg;

   localparam int unsigned BES_NUM_STEPS = 7;
   localparam int unsigned BES_NUM_PINS  = 3;

   typedef enum logic [1:0] {
      PIN_RST  = 2'd0,
      PIN_TEST = 2'd1,
      PIN_TCK  = 2'd2
   } bes_pin_e;

   typedef struct packed {
      bes_pin_e pin;
      logic     level;
   } bes_step_t;

endpackage

// File: rtl/bes_pattern.sv
module bes_pattern
   import bes_pkg::*;
#(
   parameter int unsigned NUM_STEPS = BES_NUM_STEPS,
   localparam int unsigned IW       = $clog2(NUM_STEPS)
) (
   input  logic [IW-1:0] idx_i,
   input  logic          dedicated_i,
   output bes_step_t     step_o
);

   bes_step_t ded_step;
   bes_step_t shr_step;

   // dedicated-pin pattern: TCK clocks while reset pulses low
   always_comb begin
      case (idx_i)
         3'd0:    ded_step = '{PIN_TCK, 1'b1};
         3'd1:    ded_step = '{PIN_RST, 1'b0};
         3'd2:    ded_step = '{PIN_TCK, 1'b0};
         3'd3:    ded_step = '{PIN_TCK, 1'b1};
         3'd4:    ded_step = '{PIN_TCK, 1'b0};
         3'd5:    ded_step = '{PIN_RST, 1'b1};
         default: ded_step = '{PIN_TCK, 1'b1};
      endcase
   end

   // shared-pin pattern: TEST pulses twice while reset is low
   always_comb begin
      case (idx_i)
         3'd0:    shr_step = '{PIN_RST,  1'b0};
         3'd1:    shr_step = '{PIN_TEST, 1'b0};
         3'd2:    shr_step = '{PIN_TEST, 1'b1};
         3'd3:    shr_step = '{PIN_TEST, 1'b0};
         3'd4:    shr_step = '{PIN_TEST, 1'b1};
         3'd5:    shr_step = '{PIN_RST,  1'b1};
         default: shr_step = '{PIN_TEST, 1'b0};
      endcase
   end

   assign step_o = dedicated_i ? ded_step : shr_step;

   generate
      if (NUM_STEPS != 7) begin : g_bad_steps
         $error("bes_pattern: the step tables hold exactly seven steps");
      end
   endgenerate

endmodule

// File: rtl/bes_step_timer.sv
module bes_step_timer #(
   parameter int unsigned STEP_CYCLES = 1259,
   localparam int unsigned CW         = $clog2(STEP_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic run_i,
   output logic expire_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= CW'(STEP_CYCLES - 1);
      end else if (run_i && cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign expire_o = run_i && (cnt_q == '0);

   // R5: the gap counter never exceeds the programmed spacing
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(STEP_CYCLES - 1));

   generate
      if (STEP_CYCLES < 1) begin : g_bad_gap
         $error("bes_step_timer: STEP_CYCLES must be at least 1");
      end
   endgenerate

endmodule

// File: rtl/boot_entry_seq.sv
module boot_entry_seq
   import bes_pkg::*;
#(
   parameter int unsigned STEP_CYCLES = 1259
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic dedicated_i,
   output logic tgt_rst_n_o,
   output logic tgt_test_o,
   output logic tgt_tck_o,
   output logic busy_o,
   output logic done_o
);

   localparam int unsigned NSTEP = BES_NUM_STEPS;
   localparam int unsigned NPIN  = BES_NUM_PINS;
   localparam int unsigned IW    = $clog2(NSTEP);

   logic            busy_q, done_q, mode_q;
   logic [IW-1:0]   idx_q;
   logic [NPIN-1:0] pins_q;
   logic            start_acc, expire, last_step, apply_step, load_gap;
   logic            cur_mode;
   logic [IW-1:0]   cur_idx;
   bes_step_t       step;

   assign start_acc  = start_i && !busy_q;
   assign last_step  = busy_q && (idx_q == IW'(NSTEP - 1));
   assign apply_step = start_acc || expire;
   assign load_gap   = start_acc || (expire && !last_step);
   assign cur_mode   = busy_q ? mode_q : dedicated_i;
   assign cur_idx    = busy_q ? idx_q : '0;

   bes_pattern #(.NUM_STEPS(NSTEP)) u_pattern (
      .idx_i       (cur_idx),
      .dedicated_i (cur_mode),
      .step_o      (step)
   );

   bes_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_gap),
      .run_i    (busy_q),
      .expire_o (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         mode_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_acc) begin
            busy_q <= 1'b1;
            mode_q <= dedicated_i;
            idx_q  <= IW'(1);
         end else if (expire) begin
            if (last_step) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + IW'(1);
            end
         end
      end
   end

   for (genvar g = 0; g < NPIN; g++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pins_q[g] <= 1'b0;
         end else if (apply_step && (step.pin == 2'(g))) begin
            pins_q[g] <= step.level;
         end
      end
   end

   assign tgt_rst_n_o = pins_q[PIN_RST];
   assign tgt_test_o  = pins_q[PIN_TEST];
   assign tgt_tck_o   = pins_q[PIN_TCK];
   assign busy_o      = busy_q;
   assign done_o      = done_q;

   // R2: an idle start request makes the block busy
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_q) |=> busy_q);

   // R5: at most one line moves on any edge
   p_one_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pins_q ^ $past(pins_q)) <= 1);

   // R6: done lasts one cycle and only while idle
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

   // R7: a request while busy cannot cut a pattern short
   p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && !last_step) |=> busy_q);

   // R8: captured strap is frozen for the whole pattern
   p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> (!busy_q || $stable(mode_q)));

   // R9: idle lines hold their levels
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start_i) |=> $stable(pins_q));

endmodule

// File: tb/boot_entry_seq_tb.sv
module boot_entry_seq_tb;

   localparam int unsigned D = 5;

   // step code {pin[1:0], level}; pin 0 = reset, 1 = TEST, 2 = TCK
   localparam logic [20:0] DED = {3'b101, 3'b001, 3'b100, 3'b101, 3'b100, 3'b000, 3'b101};
   localparam logic [20:0] SHR = {3'b010, 3'b001, 3'b011, 3'b010, 3'b011, 3'b010, 3'b000};

   // row = {strap, disturb, codes}
   localparam logic [22:0] ROWS [4] = '{
      {1'b1, 1'b0, DED},
      {1'b0, 1'b0, SHR},
      {1'b0, 1'b1, SHR},
      {1'b1, 1'b1, DED}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic dedicated_i = 1'b0;
   logic tgt_rst_n_o, tgt_test_o, tgt_tck_o, busy_o, done_o;

   int errors = 0;
   int checks = 0;
   logic [2:0] model = 3'b000;   // {reset, TEST, TCK}

   always #10 clk = ~clk;

   boot_entry_seq #(.STEP_CYCLES(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dedicated_i(dedicated_i),
      .tgt_rst_n_o(tgt_rst_n_o), .tgt_test_o(tgt_test_o), .tgt_tck_o(tgt_tck_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   function automatic logic [2:0] apply_code(logic [2:0] p, logic [2:0] c);
      logic [2:0] r = p;
      case (c[2:1])
         2'd0:    r[2] = c[0];
         2'd1:    r[1] = c[0];
         default: r[0] = c[0];
      endcase
      return r;
   endfunction

   function automatic logic [4:0] obs();
      return {tgt_rst_n_o, tgt_test_o, tgt_tck_o, busy_o, done_o};
   endfunction

   task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %05b expected %05b", tag, got, exp);
      end
   endtask

   task automatic run_seq(input logic mode, input logic disturb, input logic [20:0] codes,
                          input logic chain, input logic nmode, input logic [20:0] ncodes);
      @(negedge clk);
      start_i = 1'b1;
      dedicated_i = mode;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      model = apply_code(model, codes[2:0]);
      check("R2 accept and first step", obs(), {model, 2'b10});
      for (int k = 1; k < 7; k++) begin
         repeat (D - 1) @(posedge clk);
         @(negedge clk);
         check("R5 lines quiet between steps", obs(), {model, 2'b10});
         if (disturb && (k == 3 || k == 6)) begin
            start_i = 1'b1;          // R7 ignored request on a step edge
            dedicated_i = ~mode;     // R8 strap flip mid-pattern
         end
         @(posedge clk);
         @(negedge clk);
         start_i = 1'b0;
         dedicated_i = mode;
         model = apply_code(model, codes[3*k +: 3]);
         if (k < 6)
            check(mode ? "R3 dedicated step" : "R4 shared step", obs(), {model, 2'b10});
         else
            check("R6 final step with done", obs(), {model, 2'b01});
      end
      if (chain) begin
         start_i = 1'b1;
         dedicated_i = nmode;
         @(posedge clk);
         @(negedge clk);
         start_i = 1'b0;
         model = apply_code(model, ncodes[2:0]);
         check("R10 start in done cycle", obs(), {model, 2'b10});
         for (int k = 1; k < 7; k++) begin
            repeat (D) @(posedge clk);
            model = apply_code(model, ncodes[3*k +: 3]);
         end
         @(negedge clk);
         check("R10 chained pattern end", obs(), {model, 2'b01});
      end
      @(posedge clk);
      @(negedge clk);
      check("R6 done drops after one cycle", obs(), {model, 2'b00});
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 lines hold while idle", obs(), {model, 2'b00});
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset levels", obs(), 5'b00000);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 idle after reset", obs(), 5'b00000);

      for (int r = 0; r < 4; r++)
         run_seq(ROWS[r][22], ROWS[r][21], ROWS[r][20:0], 1'b0, 1'b0, 21'd0);

      // directed R10: dedicated pattern chained straight into a shared one
      run_seq(1'b1, 1'b0, DED, 1'b1, 1'b0, SHR);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule